// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor

This block sits between the analog protection comparators of a three-phase inverter and the gate command logic. It takes one digital overcurrent flag and, for each monitored supply (low-side and high-side), a pair of flags. One flag of the pair reports that the supply has risen above its upper threshold. The other reports that it has fallen below its lower threshold. From these inputs it drives a single gate-disable line, which the gate command logic uses to force all six switches off. It also drives a two-bit cause code.

The overcurrent flag must stay high for a programmable number of consecutive cycles before it counts as an event. A qualified event starts a latched shutdown. The shutdown lasts a fixed fault-clear interval of `CLEAR_CYCLES` cycles (235,000 at 50 MHz, about 4.7 ms). It then releases by itself, unless the overcurrent is still qualified at expiry. In that case a new full interval begins.

Each supply has its own hysteretic lockout. A supply starts locked out at reset, is released by its above-upper flag, and is locked again by its below-lower flag. Any locked supply holds the outputs disabled.

Top module: `fault_supervisor`

## Requirements
- R1: The overcurrent input is qualified only after it is sampled high on `FILT_CYCLES` consecutive clock edges. Any shorter high run, however often it repeats, leaves `gateDisable` and `faultCause` unchanged.
- R2: When the input is first sampled high at edge k and held, `gateDisable` rises after edge k+`FILT_CYCLES` and not before.
- R3: An overcurrent shutdown keeps `gateDisable` high for exactly `CLEAR_CYCLES` cycles. It then releases if the input is no longer qualified.
- R4: If the overcurrent is still qualified on the last cycle of the interval, a new full interval of `CLEAR_CYCLES` cycles follows with no gap.
- R5: Overcurrent pulses that arrive during a shutdown, other than a qualification still present on its last cycle, do not lengthen it.
- R6: After reset both supplies are locked out and `gateDisable` is high. A supply is released one cycle after its above-upper flag is sampled high. It stays locked while neither of its flags is high.
- R7: A released supply locks one cycle after its below-lower flag is sampled high. It stays locked until its above-upper flag is seen again; with neither flag high, the state holds.
- R8: When both flags of one supply are high on the same edge, the supply ends up locked.
- R9: Bit 0 of the supply flag vectors is the low-side supply and bit 1 is the high-side supply. Each supply has its own lockout, and either one being locked asserts `gateDisable`.
- R10: `faultCause` is 2'b00 with no fault, 2'b01 with only an overcurrent shutdown, 2'b10 with only a lockout, and 2'b11 with both. `gateDisable` is high exactly when `faultCause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ocRaw | input | 1 | Overcurrent comparator flag, active high |
| supplyAboveHi | input | NUM_SUPPLIES | Per supply: above upper threshold (bit 0 low-side, bit 1 high-side) |
| supplyBelowLo | input | NUM_SUPPLIES | Per supply: below lower threshold |
| gateDisable | output | 1 | Forces all gate outputs off |
| faultCause | output | 2 | Current cause code |

## Verification
The bench goes after overcurrent runs one cycle shorter than the filter length and runs of exactly that length. A filter with an off-by-one would either trip on glitches or miss marginal events. It measures the shutdown length to the cycle, holds the overcurrent through expiry, and pulses it in the middle of a shutdown. A timer that was wrong would release early, leave a one-cycle gap before restarting, or stretch on every pulse. The supply flags are driven through the hysteresis cases: both flags low, both flags high together, and each supply alone. This exposes lockouts that release without the upper flag, that favour release on a conflict, or that cross the two supplies.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStart;   // load fault-clear timer with zero
    logic clrStep;    // advance fault-clear timer
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OC   = 2'b01,
    CAUSE_UV   = 2'b10,
    CAUSE_BOTH = 2'b11
  } cause_t;

  typedef enum logic {
    TRIP_IDLE   = 1'b0,
    TRIP_ACTIVE = 1'b1
  } trip_state_t;

endpackage

// File: rtl/fault_sup_datapath.sv
module fault_sup_datapath
  import fault_sup_pkg::*;
#(
  parameter int FILT_CYCLES  = 10,
  parameter int CLEAR_CYCLES = 235000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ocRaw,
  input  ctrl_strobe_t strobe,
  output logic         ocValid,
  output logic         clrDone
);

  localparam int FILT_W = $clog2(FILT_CYCLES + 1);
  localparam int CLR_W  = $clog2(CLEAR_CYCLES);
  localparam logic [FILT_W-1:0] FILT_MAX = FILT_W'(FILT_CYCLES);
  localparam logic [CLR_W-1:0]  CLR_LAST = CLR_W'(CLEAR_CYCLES - 1);

  logic [FILT_W-1:0] runCnt;
  logic [CLR_W-1:0]  clearCnt;

  // consecutive-high run counter, saturating at the filter length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!ocRaw) begin
      runCnt <= '0;
    end else if (runCnt != FILT_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign ocValid = (runCnt == FILT_MAX);

  // fault-clear interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearCnt <= '0;
    end else if (strobe.clrStart) begin
      clearCnt <= '0;
    end else if (strobe.clrStep) begin
      clearCnt <= clearCnt + 1'b1;
    end
  end

  assign clrDone = (clearCnt == CLR_LAST);

  AST_FILT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    !ocRaw |=> !ocValid);                                          // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStep |-> !clrDone);                                  // R3

endmodule

// File: rtl/fault_sup_ctrl.sv
module fault_sup_ctrl
  import fault_sup_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ocValid,
  input  logic         clrDone,
  output ctrl_strobe_t strobe,
  output logic         ocTrip
);

  trip_state_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe.clrStart = 1'b0;
    strobe.clrStep  = 1'b0;
    unique case (state)
      TRIP_IDLE: begin
        if (ocValid) begin
          stateNext       = TRIP_ACTIVE;
          strobe.clrStart = 1'b1;
        end
      end
      TRIP_ACTIVE: begin
        if (!clrDone) begin
          strobe.clrStep = 1'b1;
        end else if (ocValid) begin
          strobe.clrStart = 1'b1;   // restart a full interval
        end else begin
          stateNext = TRIP_IDLE;
        end
      end
      default: stateNext = TRIP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= TRIP_IDLE;
    else       state <= stateNext;
  end

  assign ocTrip = (state == TRIP_ACTIVE);

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ocTrip && !clrDone) |=> ocTrip);                              // R3

  AST_TRIP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (ocTrip && clrDone && ocValid) |=> (ocTrip && !clrDone));      // R4

  AST_TRIP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (ocTrip && clrDone && !ocValid) |=> !ocTrip);                  // R3

endmodule

// File: rtl/fault_sup_uvlock.sv
module fault_sup_uvlock (
  input  logic clk,
  input  logic rstN,
  input  logic aboveHi,
  input  logic belowLo,
  output logic locked
);

  // below-lower wins over above-upper
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        locked <= 1'b1;
    else if (belowLo) locked <= 1'b1;
    else if (aboveHi) locked <= 1'b0;
  end

  AST_UV_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    belowLo |=> locked);                                           // R7

  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !aboveHi) |=> locked);                              // R6

  AST_UV_STAY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !belowLo) |=> !locked);                            // R7

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int FILT_CYCLES  = 10,
  parameter int CLEAR_CYCLES = 235000,
  parameter int NUM_SUPPLIES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ocRaw,
  input  logic [NUM_SUPPLIES-1:0] supplyAboveHi,
  input  logic [NUM_SUPPLIES-1:0] supplyBelowLo,
  output logic                    gateDisable,
  output logic [1:0]              faultCause
);

  ctrl_strobe_t            strobe;
  logic                    ocValid;
  logic                    clrDone;
  logic                    ocTrip;
  logic [NUM_SUPPLIES-1:0] uvLocked;
  logic                    uvAny;
  cause_t                  cause;

  fault_sup_datapath #(
    .FILT_CYCLES (FILT_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .ocRaw  (ocRaw),
    .strobe (strobe),
    .ocValid(ocValid),
    .clrDone(clrDone)
  );

  fault_sup_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ocValid(ocValid),
    .clrDone(clrDone),
    .strobe (strobe),
    .ocTrip (ocTrip)
  );

  for (genvar s = 0; s < NUM_SUPPLIES; s++) begin : gSupply
    fault_sup_uvlock uLock (
      .clk    (clk),
      .rstN   (rstN),
      .aboveHi(supplyAboveHi[s]),
      .belowLo(supplyBelowLo[s]),
      .locked (uvLocked[s])
    );
  end

  assign uvAny       = |uvLocked;
  assign cause       = cause_t'({uvAny, ocTrip});
  assign faultCause  = cause;
  assign gateDisable = (cause != CAUSE_NONE);

  AST_OC_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    ocValid |=> gateDisable);                                      // R2

  AST_UV_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (|supplyBelowLo) |=> (gateDisable && faultCause[1]));          // R9

endmodule

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;

  localparam int F = 4;
  localparam int C = 40;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ocRaw = 1'b0;
  logic [NS-1:0] aboveHi = '0;
  logic [NS-1:0] belowLo = '0;
  logic          gateDisable;
  logic [1:0]    faultCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state (value after the most recent edge)
  int     mRun = 0;
  bit     mTrip = 1'b0;
  int     mRem = 0;
  bit [NS-1:0] mLock = '1;

  fault_supervisor #(
    .FILT_CYCLES(F), .CLEAR_CYCLES(C), .NUM_SUPPLIES(NS)
  ) dut (
    .clk(clk), .rstN(rstN), .ocRaw(ocRaw),
    .supplyAboveHi(aboveHi), .supplyBelowLo(belowLo),
    .gateDisable(gateDisable), .faultCause(faultCause)
  );

  always #5 clk = ~clk;

  function automatic bit [1:0] expCause();
    return {|mLock, mTrip};
  endfunction

  // advance model by one edge using the inputs currently applied
  task automatic modelEdge();
    bit qual;
    qual = (mRun >= F);
    if (!mTrip) begin
      if (qual) begin mTrip = 1'b1; mRem = C; end
    end else if (mRem == 1) begin
      if (qual) mRem = C;
      else      mTrip = 1'b0;
    end else begin
      mRem = mRem - 1;
    end
    mRun = ocRaw ? ((mRun + 1 > F) ? F : mRun + 1) : 0;
    for (int s = 0; s < NS; s++) begin
      if (belowLo[s])      mLock[s] = 1'b1;
      else if (aboveHi[s]) mLock[s] = 1'b0;
    end
  endtask

  task automatic cmp(input string tag);
    bit [1:0] ec;
    ec = expCause();
    checks++;
    if (faultCause !== ec || gateDisable !== (ec != 2'b00)) begin
      errors++;
      $display("FAIL %s: cause=%b dis=%b expected cause=%b dis=%b at %0t",
               tag, faultCause, gateDisable, ec, (ec != 2'b00), $time);
    end
  endtask

  task automatic tick(input string tag);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic expectDis(input bit v, input string tag);
    checks++;
    if (gateDisable !== v) begin
      errors++;
      $display("FAIL %s: gateDisable=%b expected %b at %0t", tag, gateDisable, v, $time);
    end
  endtask

  int seedDummy;
  int tripLen;

  initial begin
    seedDummy = $urandom(32'h5A17C0DE);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmp("R6 reset state");
    expectDis(1'b1, "R6 disabled after reset");

    // stays locked with no flags
    repeat (3) tick("R6 locked without upper flag");
    aboveHi = 2'b01; tick("R9 low-side released alone");
    expectDis(1'b1, "R9 high-side still locked");
    aboveHi = 2'b10; tick("R6 both released");
    aboveHi = 2'b00; tick("R10 no fault");
    expectDis(1'b0, "R10 clear");

    // R1: runs of F-1 repeated
    for (int n = 0; n < 5; n++) begin
      ocRaw = 1'b1; repeat (F - 1) tick("R1 short run");
      ocRaw = 1'b0; tick("R1 short run gap");
    end
    expectDis(1'b0, "R1 short runs ignored");

    // R2: exact latency, run of exactly F
    ocRaw = 1'b1;
    repeat (F) tick("R2 qualifying");
    expectDis(1'b0, "R2 not before filter+1");
    ocRaw = 1'b0;
    tick("R2 trip");
    expectDis(1'b1, "R2 trip edge");

    // R3: exact length
    tripLen = 1;
    while (gateDisable && tripLen < 3 * C) begin tick("R3 interval"); if (gateDisable) tripLen++; end
    checks++;
    if (tripLen != C) begin
      errors++;
      $display("FAIL R3: shutdown length=%0d expected %0d", tripLen, C);
    end

    // R4: hold through expiry -> restart
    ocRaw = 1'b1;
    repeat (F + 1 + C + C / 2) tick("R4 held restart");
    expectDis(1'b1, "R4 still disabled after first interval");
    ocRaw = 1'b0;
    repeat (2 * C) tick("R4 release after drop");
    expectDis(1'b0, "R4 released");

    // R5: pulses mid-shutdown do not extend
    ocRaw = 1'b1; repeat (F + 1) tick("R5 trip");
    ocRaw = 1'b0; repeat (C / 4) tick("R5 mid");
    ocRaw = 1'b1; repeat (F + 2) tick("R5 pulse during trip");
    ocRaw = 1'b0; repeat (C) tick("R5 release");
    expectDis(1'b0, "R5 not extended");

    // R7/R8 hysteresis
    belowLo = 2'b01; tick("R7 low-side lock");
    belowLo = 2'b00; repeat (4) tick("R7 hold with no flags");
    expectDis(1'b1, "R7 held");
    aboveHi = 2'b01; belowLo = 2'b01; tick("R8 both flags lock");
    aboveHi = 2'b01; belowLo = 2'b00; tick("R7 release");
    aboveHi = 2'b00;
    aboveHi = 2'b10; belowLo = 2'b10; tick("R8 high-side both");
    aboveHi = 2'b00; belowLo = 2'b00; tick("R9 high-side locked");
    ocRaw = 1'b1; repeat (F + 2) tick("R10 both causes");
    checks++;
    if (faultCause !== 2'b11) begin
      errors++;
      $display("FAIL R10: cause=%b expected 11", faultCause);
    end
    ocRaw = 1'b0; aboveHi = 2'b10; tick("R10 oc only");
    aboveHi = 2'b00; repeat (C) tick("R10 drain");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) ocRaw = ~ocRaw;
      for (int s = 0; s < NS; s++) begin
        aboveHi[s] = ($urandom_range(0, 9) == 0);
        belowLo[s] = ($urandom_range(0, 59) == 0);
      end
      tick("R10 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule